// File: doc/BRIEF.md
# Host-Side Byte Register File with Request Output

This block is the part of a DSP host port that faces an external byte-wide host processor. The host sees eight byte locations selected by a 3-bit address. Four of them hold control and status: a transfer control byte, a command vector byte, a status byte and an interrupt vector byte. Location 4 is empty. The last three locations carry one 24-bit data word in three bytes. When written, they feed a transmit word going toward the DSP. When read, they return a receive word coming from the DSP.

Both data directions are double buffered. On the transmit side, the host fills a holding word. The block then moves that word into a DSP-facing register as soon as that register is free, and shows it with a valid flag. On the receive side, the DSP drops a word into a pending buffer. The block promotes it to the host-readable bytes once the previous word has been read, and it pulses a taken strobe back to the DSP. A single request output tells the host when to act. A 2-bit mode field decides what it means. In mode 00 it is an interrupt built from enabled full/empty conditions. In modes 01, 10 and 11 it is a DMA request whose direction comes from the two enable bits.

Top module: `host_byte_regs`

## Requirements
- R1: Synchronous active-high reset sets control byte (addr 0) to 0x00, command byte (addr 1) to 0x12, status byte (addr 2) to 0x06, vector byte (addr 3) to 0x0F, clears tx_valid and hp_req, and addr 4 reads 0x00; a reset in mid-operation clears both request enables again.
- R2: Control byte layout: bit0 receive enable, bit1 transmit enable, bit2 reserved reading 0, bit3 flag 0, bit4 flag 1, bits 6:5 mode (00 interrupt, 01/10/11 DMA), bit7 init action reading 0; flags 0/1 drive host_flag0/host_flag1.
- R3: Status byte layout: bit7 request output, bit6 set when mode is not 00, bit5 zero, bit4 dsp_flag3, bit3 dsp_flag2, bit2 transmitter ready, bit1 transmit empty, bit0 receive full; writes to addr 2 and addr 4 change nothing.
- R4: Command byte: bit7 command pending (drives cmd_pending), bit6 reads 0, bits 5:0 vector (drives cmd_vector); a cmd_ack pulse clears the pending bit and keeps the vector. The vector byte at addr 3 stores all 8 bits.
- R5: Writes to addr 5, 6, 7 fill the high, middle and low transmit bytes; a write to addr 7 clears transmit empty at that clock edge.
- R6: While transmit empty is 0 and tx_valid is 0, the next edge copies the word to tx_word, sets tx_valid and sets transmit empty again; tx_valid and tx_word hold until tx_taken; transmitter ready equals transmit empty and not tx_valid.
- R7: rx_load captures rx_word only when no word is pending; a pending word moves to the host bytes on the first edge with receive full at 0, which sets receive full and pulses rx_taken for one cycle; loads made while a word is pending are dropped.
- R8: A read strobe at addr 7 clears receive full; reads at addr 5 and 6 leave it set, and writes to addresses 5 to 7 never change the receive bytes.
- R9: In mode 00 hp_req = (receive enable and receive full) or (transmit enable and transmit empty).
- R10: In a DMA mode, with only receive enable set hp_req follows receive full; with only transmit enable set it follows transmit empty; with neither set it is 0.
- R11: In a DMA mode with both enables set hp_req stays 0.
- R12: Writing the control byte with bit7 set also sets transmit empty to 1 and receive full to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hp_addr | input | 3 | Host register select |
| hp_wdata | input | 8 | Host write data |
| hp_wr | input | 1 | Host write strobe, one cycle per write |
| hp_rd | input | 1 | Host read strobe, one cycle per read |
| hp_rdata | output | 8 | Read data for the selected register |
| hp_req | output | 1 | Host request (interrupt or DMA) |
| host_flag0 | output | 1 | Host-to-DSP flag 0 |
| host_flag1 | output | 1 | Host-to-DSP flag 1 |
| dsp_flag2 | input | 1 | DSP-to-host flag 2 |
| dsp_flag3 | input | 1 | DSP-to-host flag 3 |
| cmd_pending | output | 1 | Host command outstanding |
| cmd_vector | output | 6 | Host command vector |
| cmd_ack | input | 1 | DSP acknowledge of the host command |
| tx_word | output | 24 | Transmit word toward the DSP |
| tx_valid | output | 1 | Transmit word is valid |
| tx_taken | input | 1 | DSP consumed the transmit word |
| rx_word | input | 24 | Receive word from the DSP |
| rx_load | input | 1 | DSP offers rx_word |
| rx_taken | output | 1 | Pending receive word moved to the host bytes |

## Verification
The hardest state to reach from the ports is a full pipeline in both directions. In that state the host has refilled the transmit word while the DSP still holds the earlier one, and a second receive word sits pending behind an unread one. Only in that state does transmit empty stay low and a late load get dropped. The stimulus gets there by holding back tx_taken and the low-byte read, issuing a second low-byte write and two more loads, and only then releasing the first words. The request decode is then swept through every mode and enable pattern, plus random control bytes, in each of the four empty/full combinations built this way.

// File: rtl/hostport_pkg.sv
package hostport_pkg;

    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;
    localparam int NBYTES = 3;
    localparam int WORD_W = NBYTES * BYTE_W;
    localparam int VEC_W  = 6;
    localparam int DBASE  = (1 << ADDR_W) - NBYTES;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_IVEC = 3'd3;
    localparam logic [ADDR_W-1:0] A_GAP  = 3'd4;
    localparam logic [ADDR_W-1:0] A_DLO  = 3'd7;

    localparam logic [BYTE_W-1:0] IVEC_RST   = 8'h0F;
    localparam logic [VEC_W-1:0]  CMDVEC_RST = 6'h12;

    typedef enum logic [1:0] {
        XFER_IRQ   = 2'b00,
        XFER_DMA24 = 2'b01,
        XFER_DMA16 = 2'b10,
        XFER_DMA8  = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        logic       init;
        xfer_mode_e mode;
        logic       hf1;
        logic       hf0;
        logic       rsv;
        logic       tx_en;
        logic       rx_en;
    } ctrl_t;

    typedef struct packed {
        logic req;
        logic dma;
        logic rsv;
        logic hf3;
        logic hf2;
        logic trdy;
        logic txde;
        logic rxdf;
    } stat_t;

    function automatic logic req_calc(xfer_mode_e mode, logic rx_en, logic tx_en,
                                      logic txde, logic rxdf);
        logic r;
        if (mode == XFER_IRQ) begin
            r = (rx_en & rxdf) | (tx_en & txde);
        end else begin
            case ({tx_en, rx_en})
                2'b01:   r = rxdf;
                2'b10:   r = txde;
                default: r = 1'b0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/hp_ctrl_regs.sv
module hp_ctrl_regs
    import hostport_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                hc_ack,
    output ctrl_t               ctrl,
    output logic                hc,
    output logic [VEC_W-1:0]    hc_vec,
    output logic [BYTE_W-1:0]   ivec,
    output logic                init_pulse
);

    logic ctrl_wr;
    assign ctrl_wr    = wr && (addr == A_CTRL);
    assign init_pulse = ctrl_wr && wdata[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            hc     <= 1'b0;
            hc_vec <= CMDVEC_RST;
            ivec   <= IVEC_RST;
        end else begin
            if (ctrl_wr) begin
                ctrl.init  <= 1'b0;
                ctrl.mode  <= xfer_mode_e'(wdata[6:5]);
                ctrl.hf1   <= wdata[4];
                ctrl.hf0   <= wdata[3];
                ctrl.rsv   <= 1'b0;
                ctrl.tx_en <= wdata[1];
                ctrl.rx_en <= wdata[0];
            end
            if (wr && (addr == A_CMD)) begin
                hc     <= wdata[7];
                hc_vec <= wdata[VEC_W-1:0];
            end else if (hc_ack) begin
                hc <= 1'b0;
            end
            if (wr && (addr == A_IVEC)) begin
                ivec <= wdata;
            end
        end
    end

endmodule

// File: rtl/hp_tx_path.sv
module hp_tx_path
    import hostport_pkg::*;
#(
    parameter int NB = NBYTES
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [BYTE_W-1:0]         wdata,
    input  logic                      init_pulse,
    input  logic                      tx_taken,
    output logic [NB-1:0][BYTE_W-1:0] tx_word,
    output logic                      tx_valid,
    output logic                      txde,
    output logic                      trdy
);

    localparam int BASE = (1 << ADDR_W) - NB;
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE + NB - 1);

    logic [NB-1:0][BYTE_W-1:0] hold;
    logic lo_wr;

    assign lo_wr = wr && (addr == LO_ADDR);
    assign trdy  = txde && !tx_valid;

    for (genvar i = 0; i < NB; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(BASE + i);
        always_ff @(posedge clk) begin
            if (rst) begin
                hold[NB-1-i] <= '0;
            end else if (wr && (addr == SLOT_A)) begin
                hold[NB-1-i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_word  <= '0;
            tx_valid <= 1'b0;
            txde     <= 1'b1;
        end else begin
            if (tx_valid && tx_taken) begin
                tx_valid <= 1'b0;
            end
            if (init_pulse) begin
                txde <= 1'b1;
            end else if (lo_wr) begin
                txde <= 1'b0;
            end else if (!txde && !tx_valid) begin
                tx_word  <= hold;
                tx_valid <= 1'b1;
                txde     <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hp_rx_path.sv
module hp_rx_path
    import hostport_pkg::*;
#(
    parameter int NB = NBYTES
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      init_pulse,
    input  logic                      rx_load,
    input  logic [NB*BYTE_W-1:0]      rx_word,
    output logic [NB-1:0][BYTE_W-1:0] rx_hold,
    output logic                      rxdf,
    output logic                      rx_taken
);

    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'((1 << ADDR_W) - 1);

    logic [NB*BYTE_W-1:0] rx_buf;
    logic pend;
    logic lo_rd;

    assign lo_rd = rd && (addr == LO_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_buf   <= '0;
            pend     <= 1'b0;
            rx_hold  <= '0;
            rxdf     <= 1'b0;
            rx_taken <= 1'b0;
        end else begin
            rx_taken <= 1'b0;
            if (rx_load && !pend) begin
                rx_buf <= rx_word;
                pend   <= 1'b1;
            end
            if (init_pulse || lo_rd) begin
                rxdf <= 1'b0;
            end else if (pend && !rxdf) begin
                rx_hold  <= rx_buf;
                rxdf     <= 1'b1;
                pend     <= 1'b0;
                rx_taken <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hp_req_logic.sv
module hp_req_logic
    import hostport_pkg::*;
(
    input  xfer_mode_e mode,
    input  logic       rx_en,
    input  logic       tx_en,
    input  logic       txde,
    input  logic       rxdf,
    output logic       req
);

    assign req = req_calc(mode, rx_en, tx_en, txde, rxdf);

endmodule

// File: rtl/host_byte_regs.sv
module host_byte_regs
    import hostport_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   hp_addr,
    input  logic [BYTE_W-1:0]   hp_wdata,
    input  logic                hp_wr,
    input  logic                hp_rd,
    output logic [BYTE_W-1:0]   hp_rdata,
    output logic                hp_req,
    output logic                host_flag0,
    output logic                host_flag1,
    input  logic                dsp_flag2,
    input  logic                dsp_flag3,
    output logic                cmd_pending,
    output logic [VEC_W-1:0]    cmd_vector,
    input  logic                cmd_ack,
    output logic [WORD_W-1:0]   tx_word,
    output logic                tx_valid,
    input  logic                tx_taken,
    input  logic [WORD_W-1:0]   rx_word,
    input  logic                rx_load,
    output logic                rx_taken
);

    ctrl_t ctrl;
    stat_t stat;
    logic [BYTE_W-1:0] ivec;
    logic init_pulse;
    logic txde, rxdf, trdy;
    logic [NBYTES-1:0][BYTE_W-1:0] tx_bytes;
    logic [NBYTES-1:0][BYTE_W-1:0] rx_hold;

    hp_ctrl_regs u_ctrl (
        .clk(clk), .rst(rst), .wr(hp_wr), .addr(hp_addr), .wdata(hp_wdata),
        .hc_ack(cmd_ack), .ctrl(ctrl), .hc(cmd_pending), .hc_vec(cmd_vector),
        .ivec(ivec), .init_pulse(init_pulse)
    );

    hp_tx_path #(.NB(NBYTES)) u_tx (
        .clk(clk), .rst(rst), .wr(hp_wr), .addr(hp_addr), .wdata(hp_wdata),
        .init_pulse(init_pulse), .tx_taken(tx_taken), .tx_word(tx_bytes),
        .tx_valid(tx_valid), .txde(txde), .trdy(trdy)
    );

    hp_rx_path #(.NB(NBYTES)) u_rx (
        .clk(clk), .rst(rst), .rd(hp_rd), .addr(hp_addr), .init_pulse(init_pulse),
        .rx_load(rx_load), .rx_word(rx_word), .rx_hold(rx_hold),
        .rxdf(rxdf), .rx_taken(rx_taken)
    );

    hp_req_logic u_req (
        .mode(ctrl.mode), .rx_en(ctrl.rx_en), .tx_en(ctrl.tx_en),
        .txde(txde), .rxdf(rxdf), .req(hp_req)
    );

    assign tx_word    = tx_bytes;
    assign host_flag0 = ctrl.hf0;
    assign host_flag1 = ctrl.hf1;

    always_comb begin
        stat.req  = hp_req;
        stat.dma  = (ctrl.mode != XFER_IRQ);
        stat.rsv  = 1'b0;
        stat.hf3  = dsp_flag3;
        stat.hf2  = dsp_flag2;
        stat.trdy = trdy;
        stat.txde = txde;
        stat.rxdf = rxdf;
    end

    always_comb begin
        hp_rdata = '0;
        case (hp_addr)
            A_CTRL:  hp_rdata = ctrl;
            A_CMD:   hp_rdata = {cmd_pending, 1'b0, cmd_vector};
            A_STAT:  hp_rdata = stat;
            A_IVEC:  hp_rdata = ivec;
            A_GAP:   hp_rdata = '0;
            default: begin
                for (int i = 0; i < NBYTES; i++) begin
                    if (hp_addr == ADDR_W'(DBASE + i)) hp_rdata = rx_hold[NBYTES-1-i];
                end
            end
        endcase
    end

endmodule

// File: rtl/hp_checker.sv
module hp_checker
    import hostport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr,
    input logic              rd,
    input logic              init_bit,
    input logic              req,
    input logic              txde,
    input logic              rxdf,
    input logic              tx_valid,
    input logic              tx_taken,
    input logic [WORD_W-1:0] tx_word,
    input logic              rx_taken,
    input xfer_mode_e        mode,
    input logic              rx_en,
    input logic              tx_en
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (txde && !rxdf && !tx_valid && !rx_en && !tx_en && !req)); // R1

    AST_TXDE_ON_LOW_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_DLO) |=> !txde); // R5

    AST_TX_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_taken) |=> (tx_valid && $stable(tx_word))); // R6

    AST_RX_TAKEN_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_taken |=> !rx_taken); // R7

    AST_RX_TAKEN_WITH_FULL: assert property (@(posedge clk) disable iff (rst)
        rx_taken |-> rxdf); // R7

    AST_RXDF_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_DLO) |=> !rxdf); // R8

    AST_DMA_BOTH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode != XFER_IRQ && rx_en && tx_en) |-> !req); // R11

    AST_INIT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_CTRL && init_bit) |=> (txde && !rxdf)); // R12

endmodule

bind host_byte_regs hp_checker u_chk (
    .clk(clk), .rst(rst), .addr(hp_addr), .wr(hp_wr), .rd(hp_rd),
    .init_bit(hp_wdata[7]), .req(hp_req), .txde(txde), .rxdf(rxdf),
    .tx_valid(tx_valid), .tx_taken(tx_taken), .tx_word(tx_word),
    .rx_taken(rx_taken), .mode(ctrl.mode), .rx_en(ctrl.rx_en), .tx_en(ctrl.tx_en)
);

// File: tb/tb_host_byte_regs.sv
`timescale 1ns/100ps
module tb_host_byte_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  hp_addr = '0;
    logic [7:0]  hp_wdata = '0;
    logic        hp_wr = 1'b0, hp_rd = 1'b0;
    logic [7:0]  hp_rdata;
    logic        hp_req, host_flag0, host_flag1;
    logic        dsp_flag2 = 1'b0, dsp_flag3 = 1'b0;
    logic        cmd_pending;
    logic [5:0]  cmd_vector;
    logic        cmd_ack = 1'b0;
    logic [23:0] tx_word;
    logic        tx_valid;
    logic        tx_taken = 1'b0;
    logic [23:0] rx_word = '0;
    logic        rx_load = 1'b0;
    logic        rx_taken;

    int nvec = 0;
    int nbad = 0;

    always #2 clk = ~clk;

    host_byte_regs dut (
        .clk(clk), .rst(rst), .hp_addr(hp_addr), .hp_wdata(hp_wdata),
        .hp_wr(hp_wr), .hp_rd(hp_rd), .hp_rdata(hp_rdata), .hp_req(hp_req),
        .host_flag0(host_flag0), .host_flag1(host_flag1),
        .dsp_flag2(dsp_flag2), .dsp_flag3(dsp_flag3),
        .cmd_pending(cmd_pending), .cmd_vector(cmd_vector), .cmd_ack(cmd_ack),
        .tx_word(tx_word), .tx_valid(tx_valid), .tx_taken(tx_taken),
        .rx_word(rx_word), .rx_load(rx_load), .rx_taken(rx_taken)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // expected request value derived from R9, R10, R11
    function automatic logic exp_req(logic [7:0] icr, logic te_flag, logic rf_flag);
        logic re, te;
        re = icr[0];
        te = icr[1];
        if (icr[6:5] == 2'b00) return (re & rf_flag) | (te & te_flag);
        if (re && te) return 1'b0;
        if (re) return rf_flag;
        if (te) return te_flag;
        return 1'b0;
    endfunction

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        hp_addr = a; hp_wdata = d; hp_wr = 1'b1;
        @(negedge clk);
        hp_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        hp_addr = a; hp_rd = 1'b1;
        #0.2 v = hp_rdata;
        @(negedge clk);
        hp_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        hp_addr = a;
        #0.2 v = hp_rdata;
    endtask

    task automatic dsp_load(input logic [23:0] w);
        @(negedge clk);
        rx_word = w; rx_load = 1'b1;
        @(negedge clk);
        rx_load = 1'b0;
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] icr;
        logic exp_te, exp_rf;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        peek(3'd0, v); chk("R1 ctrl", v, 8'h00);
        peek(3'd1, v); chk("R1 cmd", v, 8'h12);
        peek(3'd2, v); chk("R1 status", v, 8'h06);
        peek(3'd3, v); chk("R1 ivec", v, 8'h0F);
        peek(3'd4, v); chk("R1 gap", v, 8'h00);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 hp_req", hp_req, 0);

        // R2 control layout
        wr_reg(3'd0, 8'hFF);
        peek(3'd0, v); chk("R2 ctrl readback", v, 8'h7B);
        chk("R2 flag0", host_flag0, 1);
        chk("R2 flag1", host_flag1, 1);
        peek(3'd2, v); chk("R3 dma bit", v[6], 1);
        wr_reg(3'd0, 8'h08);
        chk("R2 flag0 only", {host_flag1, host_flag0}, 2'b01);
        wr_reg(3'd0, 8'h00);

        // R3 status layout and ignored writes
        @(negedge clk); dsp_flag2 = 1'b1;
        peek(3'd2, v); chk("R3 status hf2", v, 8'h0E);
        @(negedge clk); dsp_flag2 = 1'b0; dsp_flag3 = 1'b1;
        peek(3'd2, v); chk("R3 status hf3", v, 8'h16);
        @(negedge clk); dsp_flag3 = 1'b0;
        wr_reg(3'd2, 8'hFF);
        wr_reg(3'd4, 8'hFF);
        peek(3'd2, v); chk("R3 status after write", v, 8'h06);
        peek(3'd4, v); chk("R3 gap after write", v, 8'h00);

        // R4 command and vector bytes
        wr_reg(3'd1, 8'hC5);
        peek(3'd1, v); chk("R4 cmd readback", v, 8'h85);
        chk("R4 cmd_pending", cmd_pending, 1);
        chk("R4 cmd_vector", cmd_vector, 6'h05);
        wr_reg(3'd3, 8'hA7);
        peek(3'd3, v); chk("R4 ivec", v, 8'hA7);
        @(negedge clk); cmd_ack = 1'b1;
        @(negedge clk); cmd_ack = 1'b0;
        peek(3'd1, v); chk("R4 ack clears pending", v, 8'h05);
        chk("R4 vector kept", cmd_vector, 6'h05);

        // R5 R6 transmit handover
        wr_reg(3'd5, 8'h11);
        wr_reg(3'd6, 8'h22);
        peek(3'd2, v); chk("R5 txde before low byte", v[1], 1);
        wr_reg(3'd7, 8'h33);
        peek(3'd2, v); chk("R5 txde cleared", v[2:1], 2'b00);
        chk("R6 not yet valid", tx_valid, 0);
        @(negedge clk);
        peek(3'd2, v); chk("R6 txde back, trdy low", v[2:1], 2'b01);
        chk("R6 tx_valid", tx_valid, 1);
        chk("R6 tx_word", tx_word, 24'h112233);
        peek(3'd5, v); chk("R8 rx byte untouched by write", v, 8'h00);
        wr_reg(3'd5, 8'h44);
        wr_reg(3'd6, 8'h55);
        wr_reg(3'd7, 8'h66);
        repeat (3) @(negedge clk);
        peek(3'd2, v); chk("R6 second word waits", v[1], 0);
        chk("R6 first word held", tx_word, 24'h112233);
        @(negedge clk); tx_taken = 1'b1;
        @(negedge clk); tx_taken = 1'b0;
        chk("R6 taken clears valid", tx_valid, 0);
        @(negedge clk);
        chk("R6 second word moved", tx_word, 24'h445566);
        chk("R6 second valid", tx_valid, 1);
        peek(3'd2, v); chk("R6 txde after second", v[1], 1);
        @(negedge clk); tx_taken = 1'b1;
        @(negedge clk); tx_taken = 1'b0;
        peek(3'd2, v); chk("R6 trdy after drain", v[2:1], 2'b11);

        // R7 R8 receive handover
        dsp_load(24'hA1B2C3);
        peek(3'd2, v); chk("R7 not yet full", v[0], 0);
        chk("R7 taken idle", rx_taken, 0);
        @(negedge clk);
        peek(3'd2, v); chk("R7 full", v[0], 1);
        chk("R7 taken pulse", rx_taken, 1);
        @(negedge clk);
        chk("R7 taken one cycle", rx_taken, 0);
        dsp_load(24'hD4E5F6);
        dsp_load(24'h0BAD00);
        rd_reg(3'd5, v); chk("R8 high byte", v, 8'hA1);
        rd_reg(3'd6, v); chk("R8 mid byte", v, 8'hB2);
        peek(3'd2, v); chk("R8 full kept by mid read", v[0], 1);
        rd_reg(3'd7, v); chk("R8 low byte", v, 8'hC3);
        peek(3'd2, v); chk("R8 low read clears full", v[0], 0);
        @(negedge clk);
        peek(3'd2, v); chk("R7 pending word promoted", v[0], 1);
        chk("R7 second taken pulse", rx_taken, 1);
        rd_reg(3'd5, v); chk("R7 second high", v, 8'hD4);
        rd_reg(3'd6, v); chk("R7 second mid", v, 8'hE5);
        rd_reg(3'd7, v); chk("R7 second low", v, 8'hF6);
        repeat (2) @(negedge clk);
        peek(3'd2, v); chk("R7 late load dropped", v[0], 0);

        // R9 R10 R11 request decode in all four flag states
        for (int s = 0; s < 4; s++) begin
            case (s)
                0: begin wr_reg(3'd0, 8'h80); exp_te = 1; exp_rf = 0; end
                1: begin dsp_load(24'h123456); @(negedge clk); exp_te = 1; exp_rf = 1; end
                2: begin wr_reg(3'd7, 8'h01); @(negedge clk); wr_reg(3'd7, 8'h02);
                         exp_te = 0; exp_rf = 1; end
                default: begin rd_reg(3'd7, v); exp_te = 0; exp_rf = 0; end
            endcase
            peek(3'd2, v); chk("R12 flag setup", v[1:0], {exp_te, exp_rf});
            for (int k = 0; k < 26; k++) begin
                if (k < 16) icr = {1'b0, k[3:2], 3'b000, k[1:0]};
                else        icr = 8'($urandom()) & 8'h7F;
                wr_reg(3'd0, icr);
                peek(3'd2, v);
                if (icr[6:5] == 2'b00)
                    chk("R9 irq request", hp_req, exp_req(icr, exp_te, exp_rf));
                else if (icr[1:0] == 2'b11)
                    chk("R11 both enables quiet", hp_req, 0);
                else
                    chk("R10 dma request", hp_req, exp_req(icr, exp_te, exp_rf));
                chk("R3 status req/dma bits", v[7:6],
                    {exp_req(icr, exp_te, exp_rf), icr[6:5] != 2'b00});
            end
        end

        // R12 init clears the data flags
        dsp_load(24'h777777);
        @(negedge clk);
        peek(3'd2, v); chk("R12 rx full before init", v[0], 1);
        wr_reg(3'd0, 8'h80);
        peek(3'd2, v); chk("R12 init flags", v[1:0], 2'b10);
        peek(3'd0, v); chk("R12 init reads zero", v[7], 0);

        // R1 reset in mid-operation
        wr_reg(3'd0, 8'h03);
        dsp_load(24'h010203);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        peek(3'd0, v); chk("R1 enables cleared", v, 8'h00);
        peek(3'd2, v); chk("R1 status after reset", v, 8'h06);
        chk("R1 req after reset", hp_req, 0);
        chk("R1 tx_valid after reset", tx_valid, 0);

        finish_run();
    end

endmodule